// File: doc/BRIEF.md
# Bus-Master Block Transfer Sequencer

This block moves a run of bytes between a card-side buffer and host memory by taking over a 16-bit AT-style expansion bus as master. Software supplies a 24-bit start address, a byte count, a direction and a speed code, then pulses start. The sequencer asks for the bus with a request/grant handshake. It then issues one memory cycle after another. Each cycle has one address clock followed by a read or write strobe held low.

The width of each cycle is decided per address. Even addresses with two or more bytes left move a word. An odd address moves one byte on the upper lanes. A lone final byte at an even address moves on the lower lanes. Inside the display memory window (0xA0000 to 0xBFFFF) the target's 16-bit response is sampled in the address clock. If the target does not claim 16-bit, every access in the window becomes a byte on the lower lanes. Outside the window that response is not consulted.

The block holds the bus for a programmed on-time and then releases it for a programmed off-time before asking again. The cycle in progress always completes before release. The strobe length follows the speed code, and the ready input can stretch it. A one-clock done pulse marks the end of the block.

Top module: `busm_dma_seq`

## Requirements
- R1: While reset is asserted and after it is released, both strobes are high, `hold_req_o` is low, `busy_o` is low and `done_o` is low.
- R2: After a start with a non-zero count, `hold_req_o` rises, and no strobe goes low unless `hold_req_o` and `hold_gnt_i` are both high.
- R3: At an even address with at least two bytes remaining, where the target is treated as 16-bit, the cycle drives both lanes (`lane_lo_o`=1, `lane_hi_o`=1). The next cycle's address is 2 higher.
- R4: Where the target is treated as 16-bit, an odd address gives a byte cycle on the upper lane only (`lane_hi_o`=1, `lane_lo_o`=0). A single remaining byte at an even address gives a byte cycle on the lower lane only. Both advance the address by 1.
- R5: For addresses 0xA0000 to 0xBFFFF, `mem16_i` low during the address clock gives a byte cycle on the lower lane only, advancing by 1, whatever the alignment. `mem16_i` high there applies R3 and R4.
- R6: Outside 0xA0000 to 0xBFFFF, `mem16_i` has no effect on cycle width or lanes.
- R7: `dir_i`=1 writes host memory with `memw_n_o`; `dir_i`=0 reads it with `memr_n_o`. The two strobes are never low together, and `mem_addr_o` is stable while a strobe is low.
- R8: With the default 10 ns clock and `ready_i` high, speed codes 0, 1, 2 and 3 give total cycle times of 250, 200, 150 and 100 ns. Each cycle is one address clock plus a strobe low for 24, 19, 14 or 9 clocks.
- R9: While `ready_i` is low at a clock edge where the strobe would otherwise end, the strobe stays low.
- R10: Bus clocks held are counted from the first address clock. At the end of a cycle, once at least `on_time_i` clocks have elapsed, `hold_req_o` drops for `off_time_i` clocks before it is raised again. A value of zero selects 1100 or 400 clocks (11 us and 4 us).
- R11: `done_o` pulses for exactly one clock when the last byte completes, with `busy_o` low. A start with count zero gives the pulse without requesting the bus.
- R12: A start received while `busy_o` is high is ignored and does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| dir_i | input | 1 | 1 writes host memory, 0 reads it |
| addr_i | input | 24 | Start address in host memory |
| count_i | input | 16 | Byte count |
| speed_i | input | 2 | Cycle time code |
| on_time_i | input | 16 | Bus hold time in clocks, 0 selects default |
| off_time_i | input | 16 | Bus release time in clocks, 0 selects default |
| hold_req_o | output | 1 | Bus request |
| hold_gnt_i | input | 1 | Bus grant |
| mem16_i | input | 1 | Target claims a 16-bit access |
| ready_i | input | 1 | Target ready, low stretches the strobe |
| mem_addr_o | output | 24 | Memory address |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| lane_lo_o | output | 1 | Lower data lanes carry data this cycle |
| lane_hi_o | output | 1 | Upper data lanes carry data this cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that grant is only given while the request is high and stays up until the request is withdrawn. They also assume that the 16-bit claim is meaningful in the address clock that precedes each strobe. The bench grants two clocks after each request and withdraws the grant one clock after the request drops. It holds `mem16_i` at one level for a whole transfer, so the width decided in the address clock is the one the target would answer with. Ready is only lowered after a strobe has been seen low, and it is always raised again, so each cycle ends.

// File: rtl/busm_pkg.sv
`timescale 1ns/1ps
package busm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_STRB,
    ST_OFF
  } seq_state_e;

  typedef struct packed {
    logic lo;
    logic hi;
    logic wide;
  } lane_sel_t;

  // total cycle time in ns for each speed code
  function automatic int unsigned cycle_ns(input int unsigned code);
    case (code)
      0:       return 250;
      1:       return 200;
      2:       return 150;
      default: return 100;
    endcase
  endfunction

endpackage

// File: rtl/busm_width_sel.sv
`timescale 1ns/1ps
module busm_width_sel
  import busm_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 'hBFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  rem_i,
  input  logic              mem16_i,
  output lane_sel_t         lane_o,
  output logic [1:0]        step_o
);

  logic in_win;
  logic narrow;

  assign in_win = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
  assign narrow = in_win && !mem16_i;

  always_comb begin
    if (narrow) begin
      lane_o = '{lo: 1'b1, hi: 1'b0, wide: 1'b0};
    end else if (addr_i[0]) begin
      lane_o = '{lo: 1'b0, hi: 1'b1, wide: 1'b0};
    end else if (rem_i == CNT_W'(1)) begin
      lane_o = '{lo: 1'b1, hi: 1'b0, wide: 1'b0};
    end else begin
      lane_o = '{lo: 1'b1, hi: 1'b1, wide: 1'b1};
    end
  end

  assign step_o = lane_o.wide ? 2'd2 : 2'd1;

endmodule

// File: rtl/busm_strobe_timer.sv
`timescale 1ns/1ps
module busm_strobe_timer
  import busm_pkg::*;
#(
  parameter int unsigned CLK_NS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       run_i,
  input  logic [1:0] speed_i,
  input  logic       ready_i,
  output logic       last_o
);

  localparam int unsigned MAX_CLKS = 250 / CLK_NS;
  localparam int unsigned TMR_W    = $clog2(MAX_CLKS + 1);

  logic [TMR_W-1:0] len_tab [4];
  logic [TMR_W-1:0] tmr_q;

  // strobe low clocks = cycle clocks minus the address clock; loaded as count-1
  for (genvar g = 0; g < 4; g++) begin : g_len
    localparam int unsigned LOW_CLKS = cycle_ns(g) / CLK_NS - 1;
    assign len_tab[g] = TMR_W'(LOW_CLKS - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else if (load_i) begin
      tmr_q <= len_tab[speed_i];
    end else if (run_i && (tmr_q != '0)) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign last_o = run_i && (tmr_q == '0) && ready_i;

endmodule

// File: rtl/busm_tenure_timer.sv
`timescale 1ns/1ps
module busm_tenure_timer #(
  parameter int unsigned        TEN_W = 16,
  parameter logic [TEN_W-1:0]   DEF   = 16'd1100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TEN_W-1:0] limit_i,
  output logic             reached_o
);

  logic [TEN_W-1:0] elapsed_q;
  logic [TEN_W:0]   lim;

  assign lim = (limit_i == '0) ? {1'b0, DEF} : {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
    end else if (!run_i) begin
      elapsed_q <= '0;
    end else if (elapsed_q != '1) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  // true in the clock that completes the programmed span
  assign reached_o = run_i && (({1'b0, elapsed_q} + 1'b1) >= lim);

endmodule

// File: rtl/busm_dma_seq.sv
`timescale 1ns/1ps
module busm_dma_seq
  import busm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TEN_W   = 16,
  parameter int unsigned CLK_NS  = 10,
  parameter logic [TEN_W-1:0]  ON_DEF  = 16'd1100,
  parameter logic [TEN_W-1:0]  OFF_DEF = 16'd400,
  parameter logic [ADDR_W-1:0] WIN_LO  = 24'hA0000,
  parameter logic [ADDR_W-1:0] WIN_HI  = 24'hBFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        speed_i,
  input  logic [TEN_W-1:0]  on_time_i,
  input  logic [TEN_W-1:0]  off_time_i,
  output logic              hold_req_o,
  input  logic              hold_gnt_i,
  input  logic              mem16_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              memr_n_o,
  output logic              memw_n_o,
  output logic              lane_lo_o,
  output logic              lane_hi_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              dir_q;
  logic [1:0]        speed_q;
  logic [TEN_W-1:0]  on_q;
  logic [TEN_W-1:0]  off_q;
  lane_sel_t         lane_q;
  logic [1:0]        step_q;
  logic              done_q;

  lane_sel_t         sel_lane;
  logic [1:0]        sel_step;
  logic              stb_last;
  logic              on_hit;
  logic              off_hit;
  logic              in_strb;
  logic              owns_bus;

  assign in_strb  = (state_q == ST_STRB);
  assign owns_bus = (state_q == ST_ADDR) || in_strb;

  busm_width_sel #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_width (
    .addr_i  (addr_q),
    .rem_i   (rem_q),
    .mem16_i (mem16_i),
    .lane_o  (sel_lane),
    .step_o  (sel_step)
  );

  busm_strobe_timer #(
    .CLK_NS (CLK_NS)
  ) u_stb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == ST_ADDR),
    .run_i   (in_strb),
    .speed_i (speed_q),
    .ready_i (ready_i),
    .last_o  (stb_last)
  );

  busm_tenure_timer #(
    .TEN_W (TEN_W),
    .DEF   (ON_DEF)
  ) u_on (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (owns_bus),
    .limit_i   (on_q),
    .reached_o (on_hit)
  );

  busm_tenure_timer #(
    .TEN_W (TEN_W),
    .DEF   (OFF_DEF)
  ) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_OFF),
    .limit_i   (off_q),
    .reached_o (off_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      speed_q <= '0;
      on_q    <= '0;
      off_q   <= '0;
      lane_q  <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (count_i == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_REQ;
              addr_q  <= addr_i;
              rem_q   <= count_i;
              dir_q   <= dir_i;
              speed_q <= speed_i;
              on_q    <= on_time_i;
              off_q   <= off_time_i;
            end
          end
        end
        ST_REQ: begin
          if (hold_gnt_i) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          // width frozen from the 16-bit claim seen in the address clock
          lane_q  <= sel_lane;
          step_q  <= sel_step;
          state_q <= ST_STRB;
        end
        ST_STRB: begin
          if (stb_last) begin
            addr_q <= addr_q + ADDR_W'(step_q);
            rem_q  <= rem_q - CNT_W'(step_q);
            if (rem_q == CNT_W'(step_q)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (on_hit) begin
              state_q <= ST_OFF;
            end else begin
              state_q <= ST_ADDR;
            end
          end
        end
        ST_OFF: begin
          if (off_hit) state_q <= ST_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_req_o = (state_q == ST_REQ) || owns_bus;
  assign mem_addr_o = addr_q;
  assign memw_n_o   = !(in_strb && dir_q);
  assign memr_n_o   = !(in_strb && !dir_q);
  assign lane_lo_o  = in_strb && lane_q.lo;
  assign lane_hi_o  = in_strb && lane_q.hi;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/busm_dma_seq_chk.sv
`timescale 1ns/1ps
module busm_dma_seq_chk #(
  parameter int unsigned       ADDR_W = 24,
  parameter logic [ADDR_W-1:0] WIN_LO = 24'hA0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 24'hBFFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_req_o,
  input logic              hold_gnt_i,
  input logic              mem16_i,
  input logic              ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              memr_n_o,
  input logic              memw_n_o,
  input logic              lane_lo_o,
  input logic              lane_hi_o,
  input logic              busy_o,
  input logic              done_o
);

  logic stb;
  logic in_win;

  assign stb    = !memr_n_o || !memw_n_o;
  assign in_win = (mem_addr_o >= WIN_LO) && (mem_addr_o <= WIN_HI);

  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!memr_n_o && !memw_n_o));

  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && $past(stb)) |-> $stable(mem_addr_o));

  a_r2_strobe_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb |-> (hold_req_o && hold_gnt_i));

  a_r4_odd_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && mem_addr_o[0] && !in_win) |-> (lane_hi_o && !lane_lo_o));

  a_r5_narrow_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stb) && in_win && !$past(mem16_i)) |-> (lane_lo_o && !lane_hi_o));

  a_r9_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !ready_i) |=> stb);

  a_r10_release_after_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_req_o) |-> $past(stb));

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

endmodule

bind busm_dma_seq busm_dma_seq_chk #(
  .ADDR_W (ADDR_W),
  .WIN_LO (WIN_LO),
  .WIN_HI (WIN_HI)
) u_chk (.*);

// File: tb/tb_busm_dma_seq.sv
`timescale 1ns/1ps
module tb_busm_dma_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] count = '0;
  logic [1:0]  speed = '0;
  logic [15:0] on_time = '0;
  logic [15:0] off_time = '0;
  logic        hold_req;
  logic        gnt = 1'b0;
  logic        g1 = 1'b0;
  logic        mem16 = 1'b1;
  logic        ready = 1'b1;
  logic [23:0] mem_addr;
  logic        memr_n, memw_n, lane_lo, lane_hi, busy, done;

  int total = 0;
  int fails = 0;

  busm_dma_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .addr_i(addr),
    .count_i(count), .speed_i(speed), .on_time_i(on_time), .off_time_i(off_time),
    .hold_req_o(hold_req), .hold_gnt_i(gnt), .mem16_i(mem16), .ready_i(ready),
    .mem_addr_o(mem_addr), .memr_n_o(memr_n), .memw_n_o(memw_n),
    .lane_lo_o(lane_lo), .lane_hi_o(lane_hi), .busy_o(busy), .done_o(done)
  );

  always #5 clk = ~clk;

  // grant two clocks after request, withdrawn one clock after request drops
  always @(posedge clk) begin
    g1  <= hold_req;
    gnt <= g1 & hold_req;
  end

  // monitor
  logic [23:0] r_addr [64];
  logic        r_lo [64];
  logic        r_hi [64];
  logic        r_wr [64];
  int          r_len [64];
  int          ten_cyc [16];
  int          gap [16];
  int ncyc = 0, ntn = 0, done_cnt = 0, nogrant = 0, cur_len = 0, req_low = 0;
  logic stb, prev_stb = 1'b0, prev_req = 1'b0;

  always @(negedge clk) begin
    stb = !(memr_n & memw_n);
    if (stb && !prev_stb) begin
      if (ncyc < 64) begin
        r_addr[ncyc] = mem_addr; r_lo[ncyc] = lane_lo;
        r_hi[ncyc] = lane_hi; r_wr[ncyc] = !memw_n;
      end
      if (!(hold_req && gnt)) nogrant++;
      if (ntn > 0 && ntn <= 16) ten_cyc[ntn-1]++;
      cur_len = 1;
    end else if (stb) begin
      cur_len++;
    end
    if (!stb && prev_stb) begin
      if (ncyc < 64) r_len[ncyc] = cur_len;
      ncyc++;
    end
    if (hold_req && !prev_req) begin
      if (ntn > 0 && ntn <= 16) gap[ntn-1] = req_low;
      ntn++;
    end
    req_low = hold_req ? 0 : req_low + 1;
    if (done) done_cnt++;
    prev_stb = stb;
    prev_req = hold_req;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncyc = 0; ntn = 0; done_cnt = 0;
    for (int i = 0; i < 16; i++) begin ten_cyc[i] = 0; gap[i] = 0; end
  endtask

  function automatic int low_clks(input logic [1:0] s);
    case (s)
      2'd0: return 24;
      2'd1: return 19;
      2'd2: return 14;
      default: return 9;
    endcase
  endfunction

  task automatic run_xfer(input logic [23:0] a, input logic [15:0] n, input logic d,
                          input logic [1:0] s, input logic m16,
                          input logic [15:0] on_t, input logic [15:0] off_t);
    clear_mon();
    @(negedge clk);
    addr = a; count = n; dir = d; speed = s; mem16 = m16;
    on_time = on_t; off_time = off_t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // expected cycle sequence computed from R3..R8
  task automatic check_seq(input logic [23:0] a0, input logic [15:0] n0, input logic d,
                           input logic [1:0] s, input logic m16, input bit chk_len,
                           input string tag);
    logic [23:0] a = a0;
    int n = n0;
    int k = 0;
    bit ok = 1'b1;
    bit len_ok = 1'b1;
    bit dir_ok = 1'b1;
    while (n > 0) begin
      bit win = (a >= 24'hA0000) && (a <= 24'hBFFFF);
      bit elo, ehi;
      int st;
      if (win && !m16)      begin elo = 1; ehi = 0; st = 1; end
      else if (a[0])        begin elo = 0; ehi = 1; st = 1; end
      else if (n == 1)      begin elo = 1; ehi = 0; st = 1; end
      else                  begin elo = 1; ehi = 1; st = 2; end
      if (k < 64) begin
        if (ok && (r_addr[k] != a || r_lo[k] != elo || r_hi[k] != ehi)) begin
          ok = 0;
          chk(0, {tag, " R3/R4/R5 addr"}, r_addr[k], a);
          chk(0, {tag, " R3/R4/R5 lanes"}, {r_lo[k], r_hi[k]}, {elo, ehi});
        end
        if (chk_len && r_len[k] != low_clks(s)) len_ok = 0;
        if (r_wr[k] != d) dir_ok = 0;
      end
      a = a + 24'(st); n = n - st; k++;
    end
    if (ok) chk(1, tag, 0, 0);
    chk(ncyc == k, {tag, " R3/R4/R5 cycles"}, ncyc, k);
    if (chk_len) chk(len_ok, {tag, " R8 strobe length"}, r_len[0], low_clks(s));
    chk(dir_ok, {tag, " R7 strobe kind"}, r_wr[0], d);
    chk(done_cnt == 1, {tag, " R11 done pulses"}, done_cnt, 1);
  endtask

  // {addr, count, dir, speed, mem16, expected cycles}
  localparam logic [51:0] VEC [8] = '{
    {24'h010000, 16'd8, 1'b1, 2'd0, 1'b1, 8'd4},
    {24'h010001, 16'd6, 1'b0, 2'd1, 1'b1, 8'd4},
    {24'h0A0000, 16'd4, 1'b1, 2'd2, 1'b0, 8'd4},
    {24'h0A0001, 16'd4, 1'b0, 2'd3, 1'b1, 8'd3},
    {24'h09FFFE, 16'd4, 1'b1, 2'd0, 1'b0, 8'd3},
    {24'h0BFFFF, 16'd3, 1'b0, 2'd1, 1'b0, 8'd2},
    {24'h020000, 16'd1, 1'b1, 2'd2, 1'b0, 8'd1},
    {24'h020003, 16'd1, 1'b0, 2'd3, 1'b1, 8'd1}
  };

  initial begin
    #1_500_000;
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(memr_n && memw_n && !hold_req && !busy && !done, "R1 in reset",
        {memr_n, memw_n, hold_req, busy, done}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(memr_n && memw_n && !hold_req && !busy && !done, "R1 after reset",
        {memr_n, memw_n, hold_req, busy, done}, 5'b11000);

    // vector table: widths, lanes, strobe kind, timing (R3-R8, R6 in vector 4/6)
    for (int v = 0; v < 8; v++) begin
      run_xfer(VEC[v][51:28], VEC[v][27:12], VEC[v][11], VEC[v][10:9], VEC[v][8], 16'd0, 16'd0);
      chk(ncyc == int'(VEC[v][7:0]), $sformatf("vec%0d R3/R5/R6 table cycles", v), ncyc, VEC[v][7:0]);
      check_seq(VEC[v][51:28], VEC[v][27:12], VEC[v][11], VEC[v][10:9], VEC[v][8], 1'b1,
                $sformatf("vec%0d", v));
      chk(ntn == 1, $sformatf("vec%0d R2 requests", v), ntn, 1);
    end

    // R6: same outside transfer with mem16 low and high gives identical cycles
    run_xfer(24'h040001, 16'd5, 1'b1, 2'd3, 1'b0, 16'd0, 16'd0);
    check_seq(24'h040001, 16'd5, 1'b1, 2'd3, 1'b1, 1'b1, "r6_mem16_ignored");

    // R11: zero count
    run_xfer(24'h050000, 16'd0, 1'b1, 2'd3, 1'b1, 16'd0, 16'd0);
    chk(done_cnt == 1, "R11 zero count done", done_cnt, 1);
    chk(ncyc == 0 && ntn == 0, "R11 zero count no bus", ncyc + ntn, 0);

    // R9: ready held low stretches first strobe to 16 clocks
    fork
      run_xfer(24'h060000, 16'd4, 1'b0, 2'd3, 1'b1, 16'd0, 16'd0);
      begin
        @(negedge clk);
        while (memr_n) @(negedge clk);
        ready = 1'b0;
        repeat (15) @(negedge clk);
        ready = 1'b1;
      end
    join
    chk(r_len[0] == 16, "R9 stretched strobe", r_len[0], 16);
    chk(r_len[1] == 9, "R9 unstretched strobe", r_len[1], 9);

    // R10 tenure with in-flight completion, R12 start while busy
    fork
      run_xfer(24'h030000, 16'd16, 1'b1, 2'd3, 1'b1, 16'd25, 16'd7);
      begin
        @(negedge clk);
        while (memw_n) @(negedge clk);
        addr = 24'h000000; count = 16'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(ntn == 3, "R10 tenures", ntn, 3);
    chk(ten_cyc[0] == 3 && ten_cyc[1] == 3 && ten_cyc[2] == 2, "R10 cycles per tenure",
        ten_cyc[0] * 100 + ten_cyc[1] * 10 + ten_cyc[2], 332);
    chk(gap[0] == 7 && gap[1] == 7, "R10 off gap", gap[0], 7);
    check_seq(24'h030000, 16'd16, 1'b1, 2'd3, 1'b1, 1'b1, "r12_start_ignored");

    // R10 defaults: 1100 clocks on, 400 off at 25-clock cycles
    run_xfer(24'h070000, 16'd100, 1'b0, 2'd0, 1'b1, 16'd0, 16'd0);
    chk(ntn == 2, "R10 default tenures", ntn, 2);
    chk(ten_cyc[0] == 44 && ten_cyc[1] == 6, "R10 default on-time", ten_cyc[0], 44);
    chk(gap[0] == 400, "R10 default off-time", gap[0], 400);
    chk(done_cnt == 1 && !busy, "R11 done after long transfer", done_cnt, 1);

    chk(nogrant == 0, "R2 strobe without grant", nogrant, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule